// File: doc/BRIEF.md
# Double-Buffered Crosspoint Switch

A single-bit crosspoint that routes any of `N_IN` data inputs to each of `N_OUT` data outputs, with each output fed by at most one input. Data flows through combinationally. Only the routing state is clocked. Connection programming goes into a loading map. The live routing comes from a separate active map, and that active map changes only when an update is requested. This lets a whole new routing pattern be staged and then switched in at one clock edge. Holding the update pin asserted makes every programming write take effect at once.

There are two update sources: an active-low level pin and a one-cycle strobe. Either one copies the loading map into the active map. A broadcast overlay can send one chosen input to every output while the active map stays as it is. The next update removes the overlay, and the preserved routing comes back.

Each output has a two-bit enable mode, which is combined with a global enable pin. The block presents a data word and a drive-enable word, one bit per output.

Top module: `xpt_switch`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) does four things. It clears both maps to no-connect, turns off broadcast, and sets every enable mode to 00 (always enabled). It therefore drives `dout` and `dout_en` to all zeros.
- R2: A loading-map write with `cfg_we` high updates the loading map only. The output it targets is `cfg_out`; it connects to input `cfg_in` when `cfg_conn`=1 and becomes no-connect when `cfg_conn`=0. While `upd_n` is high and `upd_stb` is low, such a write leaves `dout` and `dout_en` unchanged.
- R3: At any clock edge where `upd_n` is low or `upd_stb` is high, the whole loading map is copied into the active map. The new routing is visible on the outputs from the following cycle.
- R4: A loading-map write in the same cycle as an update is included in that transfer. While `upd_n` is held low, each write therefore reaches the outputs one cycle later.
- R5: An output whose active entry is no-connect, with broadcast off, has `dout_en`=0 and `dout`=0 whatever the inputs are.
- R6: `dout` follows `din` combinationally in the same cycle, with no clock edge needed. A connection that an update leaves unchanged keeps forwarding data across that update.
- R7: A pulse on `bc_set` with no update in that cycle starts broadcast from the next cycle. Every output is then connected to input `bc_src`, and the active map is preserved.
- R8: An update from either source ends broadcast. The outputs return to the active map, including whatever that update transferred.
- R9: A `bc_set` pulse in the same cycle as an update has no effect.
- R10: Enable mode per output: 00 always enabled, 01 always disabled, 10 enabled when `gen_oe`=1, 11 enabled when `gen_oe`=0. The mode combines with the global enable pin in the same cycle.
- R11: A disabled output drives `dout`=0 and `dout_en`=0 even when connected. An enabled, connected output drives `dout_en`=1.
- R12: Several out-of-range codes are ignored with no state change. For loading writes, these are an output index ≥ `N_OUT` or a connect with input index ≥ `N_IN`. For broadcast, the code is a source ≥ `N_IN`. For mode writes, it is an output index ≥ `N_OUT`.
- R13: A mode write (`mode_we`, `mode_out`, `mode_val`) takes effect at the next edge and does not need an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration state |
| rst | input | 1 | Synchronous reset, active high |
| din | input | N_IN (24) | Data inputs |
| upd_n | input | 1 | Global update level, active low |
| upd_stb | input | 1 | One-cycle update strobe |
| cfg_we | input | 1 | Loading-map write enable |
| cfg_out | input | OSEL_W (5) | Output index for loading write |
| cfg_in | input | SEL_W (5) | Input index for loading write |
| cfg_conn | input | 1 | 1 = connect, 0 = no-connect |
| bc_set | input | 1 | Start broadcast |
| bc_src | input | SEL_W (5) | Broadcast source input |
| mode_we | input | 1 | Enable-mode write |
| mode_out | input | OSEL_W (5) | Output index for mode write |
| mode_val | input | 2 | Enable mode code |
| gen_oe | input | 1 | Global output enable pin |
| dout | output | N_OUT (24) | Data outputs |
| dout_en | output | N_OUT (24) | Per-output drive enable |

## Verification
The bench builds the switch with its default 24 by 24 size and 5-bit index fields. Codes 24 to 31 are therefore legal on the index ports but do not name any input or output, which makes the out-of-range rejection of R12 reachable. The bench uses the highest and lowest indices on both sides, so the edges of the select and enable words are covered. It runs broadcast, update and mode changes against several data patterns.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

    typedef enum logic [1:0] {
        EN_ALWAYS = 2'b00,
        EN_NEVER  = 2'b01,
        EN_OE_HI  = 2'b10,
        EN_OE_LO  = 2'b11
    } en_mode_e;

    function automatic logic mode_drives(en_mode_e m, logic g);
        logic r;
        case (m)
            EN_ALWAYS: r = 1'b1;
            EN_NEVER:  r = 1'b0;
            EN_OE_HI:  r = g;
            default:   r = ~g;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/xpt_cfg_map.sv
module xpt_cfg_map #(
    parameter int N_IN   = 24,
    parameter int N_OUT  = 24,
    parameter int SEL_W  = $clog2(N_IN),
    parameter int OSEL_W = $clog2(N_OUT)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [OSEL_W-1:0]               wr_out,
    input  logic [SEL_W-1:0]                wr_in,
    input  logic                            wr_conn,
    input  logic                            upd,
    output logic [N_OUT-1:0]                act_valid,
    output logic [N_OUT-1:0][SEL_W-1:0]     act_sel
);
    localparam logic [SEL_W-1:0]  IN_MAX  = SEL_W'(N_IN - 1);
    localparam logic [OSEL_W-1:0] OUT_MAX = OSEL_W'(N_OUT - 1);

    typedef struct packed {
        logic [N_OUT-1:0]            ld_valid;
        logic [N_OUT-1:0][SEL_W-1:0] ld_sel;
        logic [N_OUT-1:0]            act_valid;
        logic [N_OUT-1:0][SEL_W-1:0] act_sel;
    } map_t;

    map_t map_d, map_q;
    logic wr_ok;

    always_comb begin
        map_d = map_q;
        wr_ok = wr_en && (wr_out <= OUT_MAX) && (!wr_conn || (wr_in <= IN_MAX));
        if (wr_ok) begin
            map_d.ld_valid[wr_out] = wr_conn;
            map_d.ld_sel[wr_out]   = wr_conn ? wr_in : '0;
        end
        // transfer sees this cycle's write: transparent when update is held
        if (upd) begin
            map_d.act_valid = map_d.ld_valid;
            map_d.act_sel   = map_d.ld_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) map_q <= '0;
        else     map_q <= map_d;
    end

    assign act_valid = map_q.act_valid;
    assign act_sel   = map_q.act_sel;

endmodule

// File: rtl/xpt_ctrl.sv
module xpt_ctrl #(
    parameter int N_IN   = 24,
    parameter int N_OUT  = 24,
    parameter int SEL_W  = $clog2(N_IN),
    parameter int OSEL_W = $clog2(N_OUT)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        upd,
    input  logic                        bc_set,
    input  logic [SEL_W-1:0]            bc_src,
    input  logic                        mode_we,
    input  logic [OSEL_W-1:0]           mode_out,
    input  logic [1:0]                  mode_val,
    output logic                        bc_on,
    output logic [SEL_W-1:0]            bc_sel,
    output logic [N_OUT-1:0][1:0]       mode
);
    localparam logic [SEL_W-1:0]  IN_MAX  = SEL_W'(N_IN - 1);
    localparam logic [OSEL_W-1:0] OUT_MAX = OSEL_W'(N_OUT - 1);

    typedef struct packed {
        logic                  bc_on;
        logic [SEL_W-1:0]      bc_sel;
        logic [N_OUT-1:0][1:0] mode;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (upd) begin
            ctl_d.bc_on = 1'b0;
        end else if (bc_set && (bc_src <= IN_MAX)) begin
            ctl_d.bc_on  = 1'b1;
            ctl_d.bc_sel = bc_src;
        end
        if (mode_we && (mode_out <= OUT_MAX)) begin
            ctl_d.mode[mode_out] = mode_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign bc_on  = ctl_q.bc_on;
    assign bc_sel = ctl_q.bc_sel;
    assign mode   = ctl_q.mode;

endmodule

// File: rtl/xpt_out_lane.sv
module xpt_out_lane #(
    parameter int N_IN  = 24,
    parameter int SEL_W = $clog2(N_IN)
) (
    input  logic [N_IN-1:0]  din,
    input  logic             valid,
    input  logic [SEL_W-1:0] sel,
    input  logic             bc_on,
    input  logic [SEL_W-1:0] bc_sel,
    input  logic [1:0]       mode,
    input  logic             gen_oe,
    output logic             dout,
    output logic             dout_en
);
    import xpt_pkg::*;

    logic             conn;
    logic [SEL_W-1:0] pick;

    always_comb begin
        conn    = bc_on | valid;
        pick    = bc_on ? bc_sel : sel;
        dout_en = conn & mode_drives(en_mode_e'(mode), gen_oe);
        dout    = dout_en & din[pick];
    end

endmodule

// File: rtl/xpt_switch.sv
module xpt_switch #(
    parameter int N_IN   = 24,
    parameter int N_OUT  = 24,
    parameter int SEL_W  = $clog2(N_IN),
    parameter int OSEL_W = $clog2(N_OUT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   din,
    input  logic              upd_n,
    input  logic              upd_stb,
    input  logic              cfg_we,
    input  logic [OSEL_W-1:0] cfg_out,
    input  logic [SEL_W-1:0]  cfg_in,
    input  logic              cfg_conn,
    input  logic              bc_set,
    input  logic [SEL_W-1:0]  bc_src,
    input  logic              mode_we,
    input  logic [OSEL_W-1:0] mode_out,
    input  logic [1:0]        mode_val,
    input  logic              gen_oe,
    output logic [N_OUT-1:0]  dout,
    output logic [N_OUT-1:0]  dout_en
);
    logic                        upd_any;
    logic [N_OUT-1:0]            act_valid;
    logic [N_OUT-1:0][SEL_W-1:0] act_sel;
    logic                        bc_on;
    logic [SEL_W-1:0]            bc_sel;
    logic [N_OUT-1:0][1:0]       lane_mode;

    assign upd_any = ~upd_n | upd_stb;

    xpt_cfg_map #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W), .OSEL_W(OSEL_W)) u_map (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_out(cfg_out), .wr_in(cfg_in), .wr_conn(cfg_conn),
        .upd(upd_any),
        .act_valid(act_valid), .act_sel(act_sel)
    );

    xpt_ctrl #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W), .OSEL_W(OSEL_W)) u_ctrl (
        .clk(clk), .rst(rst), .upd(upd_any),
        .bc_set(bc_set), .bc_src(bc_src),
        .mode_we(mode_we), .mode_out(mode_out), .mode_val(mode_val),
        .bc_on(bc_on), .bc_sel(bc_sel), .mode(lane_mode)
    );

    for (genvar o = 0; o < N_OUT; o++) begin : g_lane
        xpt_out_lane #(.N_IN(N_IN), .SEL_W(SEL_W)) u_lane (
            .din(din), .valid(act_valid[o]), .sel(act_sel[o]),
            .bc_on(bc_on), .bc_sel(bc_sel), .mode(lane_mode[o]),
            .gen_oe(gen_oe), .dout(dout[o]), .dout_en(dout_en[o])
        );
    end

endmodule

// File: rtl/xpt_switch_chk.sv
module xpt_switch_chk #(
    parameter int N_IN  = 24,
    parameter int N_OUT = 24,
    parameter int SEL_W = $clog2(N_IN)
) (
    input logic                        clk,
    input logic                        rst,
    input logic [N_IN-1:0]             din,
    input logic                        upd_n,
    input logic                        upd_stb,
    input logic [N_OUT-1:0]            dout,
    input logic [N_OUT-1:0]            dout_en,
    input logic [N_OUT-1:0]            act_valid,
    input logic [N_OUT-1:0][SEL_W-1:0] act_sel,
    input logic                        bc_on,
    input logic [SEL_W-1:0]            bc_sel,
    input logic [N_OUT-1:0][1:0]       lane_mode
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (act_valid == '0) && !bc_on && (lane_mode == '0));

    p_hold_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (upd_n && !upd_stb) |=> $stable(act_valid) && $stable(act_sel));

    p_bcast_route_r7: assert property (@(posedge clk) disable iff (rst)
        bc_on |-> (dout == (dout_en & {N_OUT{din[bc_sel]}})));

    p_bcast_end_r8: assert property (@(posedge clk) disable iff (rst)
        (!upd_n || upd_stb) |=> !bc_on);

    p_idle_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (dout & ~dout_en) == '0);

    for (genvar o = 0; o < N_OUT; o++) begin : g_lane_chk
        p_nc_quiet_r5: assert property (@(posedge clk) disable iff (rst)
            (!act_valid[o] && !bc_on) |-> !dout_en[o]);
        p_never_mode_r10: assert property (@(posedge clk) disable iff (rst)
            (lane_mode[o] == 2'b01) |-> !dout_en[o]);
    end

endmodule

bind xpt_switch xpt_switch_chk #(.N_IN(N_IN), .N_OUT(N_OUT), .SEL_W(SEL_W)) u_chk (
    .clk(clk), .rst(rst), .din(din), .upd_n(upd_n), .upd_stb(upd_stb),
    .dout(dout), .dout_en(dout_en), .act_valid(act_valid), .act_sel(act_sel),
    .bc_on(bc_on), .bc_sel(bc_sel), .lane_mode(lane_mode)
);

// File: tb/xpt_switch_tb.sv
module xpt_switch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 24;
    localparam int NO = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NI-1:0] din = '0;
    logic          upd_n = 1'b1, upd_stb = 1'b0;
    logic          cfg_we = 1'b0, cfg_conn = 1'b0;
    logic [4:0]    cfg_out = '0, cfg_in = '0;
    logic          bc_set = 1'b0;
    logic [4:0]    bc_src = '0;
    logic          mode_we = 1'b0;
    logic [4:0]    mode_out = '0;
    logic [1:0]    mode_val = '0;
    logic          gen_oe = 1'b0;
    logic [NO-1:0] dout, dout_en;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // requirement-level model state
    bit m_lv[NO]; int m_ls[NO];
    bit m_av[NO]; int m_as[NO];
    bit m_bc; int m_bs;
    int m_mode[NO];

    xpt_switch u_dut (
        .clk(clk), .rst(rst), .din(din), .upd_n(upd_n), .upd_stb(upd_stb),
        .cfg_we(cfg_we), .cfg_out(cfg_out), .cfg_in(cfg_in), .cfg_conn(cfg_conn),
        .bc_set(bc_set), .bc_src(bc_src), .mode_we(mode_we), .mode_out(mode_out),
        .mode_val(mode_val), .gen_oe(gen_oe), .dout(dout), .dout_en(dout_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic model_clear();
        for (int o = 0; o < NO; o++) begin
            m_lv[o] = 0; m_ls[o] = 0; m_av[o] = 0; m_as[o] = 0; m_mode[o] = 0;
        end
        m_bc = 0; m_bs = 0;
    endtask

    // one clock edge: model advances from the inputs presented before the edge
    task automatic cycle();
        bit u;
        u = !upd_n || upd_stb;
        if (cfg_we && cfg_out < NO && (!cfg_conn || cfg_in < NI)) begin
            m_lv[cfg_out] = cfg_conn; m_ls[cfg_out] = cfg_conn ? int'(cfg_in) : 0;
        end
        if (u) for (int o = 0; o < NO; o++) begin m_av[o] = m_lv[o]; m_as[o] = m_ls[o]; end
        if (u) m_bc = 0;
        else if (bc_set && bc_src < NI) begin m_bc = 1; m_bs = int'(bc_src); end
        if (mode_we && mode_out < NO) m_mode[mode_out] = int'(mode_val);
        @(posedge clk); #1;
        cfg_we = 0; upd_stb = 0; bc_set = 0; mode_we = 0;
    endtask

    task automatic check(string req);
        logic [NO-1:0] ed, ee;
        for (int o = 0; o < NO; o++) begin
            bit en, c; int s;
            c = m_bc || m_av[o];
            s = m_bc ? m_bs : m_as[o];
            case (m_mode[o])
                0: en = 1; 1: en = 0; 2: en = gen_oe; default: en = !gen_oe;
            endcase
            ee[o] = c && en;
            ed[o] = ee[o] && din[s];
        end
        n_vec++;
        if (dout !== ed || dout_en !== ee) begin
            n_bad++;
            $display("FAIL %s: dout=%h en=%h expected dout=%h en=%h", req, dout, dout_en, ed, ee);
        end
    endtask

    task automatic wr(int o, int i, bit c);
        cfg_we = 1; cfg_out = 5'(o); cfg_in = 5'(i); cfg_conn = c;
        cycle();
    endtask

    task automatic pats(string req);
        din = 24'hA5C3_96; #1; check(req);
        din = 24'h5A3C_69; #1; check(req);
        din = 24'hFFFFFF;  #1; check(req);
        din = 24'h800001;  #1; check(req);
    endtask

    task automatic t_reset();
        din = '1; #1; check("R1");
    endtask

    task automatic t_staged();
        wr(0, 5, 1); wr(3, 23, 1); wr(23, 0, 1); wr(12, 12, 1);
        pats("R2");
        upd_n = 0; cycle(); upd_n = 1;
        pats("R3");
    endtask

    task automatic t_transparent();
        upd_n = 0;
        wr(7, 7, 1);
        pats("R4");
        wr(8, 1, 1);
        din = 24'h000002; #1; check("R4");
        upd_n = 1; cycle();
    endtask

    task automatic t_flow();
        for (int k = 0; k < 4; k++) begin
            din = 24'(1) << (k * 5); #1; check("R6");
        end
        din = 24'h800000; // in23 -> out3
        wr(0, 9, 1); upd_stb = 1; cycle();
        check("R6");
    endtask

    task automatic t_disconnect();
        wr(3, 0, 0); upd_stb = 1; cycle();
        pats("R5");
        din = '1; #1; check("R11");
    endtask

    task automatic t_bcast();
        bc_set = 1; bc_src = 5'd9; cycle();
        pats("R7");
        upd_stb = 1; cycle();
        pats("R8");
        bc_set = 1; bc_src = 5'd23; cycle();
        din = 24'h800000; #1; check("R7");
        upd_n = 0; cycle(); upd_n = 1;
        check("R8");
        bc_set = 1; bc_src = 5'd4; upd_n = 0; cycle(); upd_n = 1;
        din = 24'h000010; #1; check("R9");
    endtask

    task automatic t_modes();
        mode_we = 1; mode_out = 5'd0;  mode_val = 2'b01; cycle();
        mode_we = 1; mode_out = 5'd23; mode_val = 2'b10; cycle();
        mode_we = 1; mode_out = 5'd7;  mode_val = 2'b11; cycle();
        din = '1;
        gen_oe = 0; #1; check("R13"); check("R10");
        gen_oe = 1; #1; check("R10"); check("R11");
        mode_we = 1; mode_out = 5'd0; mode_val = 2'b00; cycle();
        check("R13");
    endtask

    task automatic t_range();
        din = 24'hC3A5_5A;
        wr(24, 3, 1); wr(31, 3, 0); wr(12, 30, 1);
        upd_stb = 1; cycle(); check("R12");
        bc_set = 1; bc_src = 5'd25; cycle(); check("R12");
        mode_we = 1; mode_out = 5'd24; mode_val = 2'b01; cycle(); check("R12");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_staged();
        t_transparent();
        t_flow();
        t_disconnect();
        t_bcast();
        t_modes();
        t_range();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule